// File: doc/BRIEF.md
# E1 Frame and Multiframe Alignment Detector

This block watches a serial 2.048 Mbit/s primary-rate stream, one bit for each cycle in which the bit-clock enable is high, and finds where frames and 16-frame multiframes begin. It starts with no alignment. It slides a 7-bit window across the stream until it sees the frame alignment word. It then confirms that position by checking the marker bit of the next frame and a second alignment word two frames later. Only after that does it declare frame alignment.

Once frame alignment is held, a position counter reports the time slot and bit of the next bit to arrive. A second state machine then looks for the all-zero signalling nibble that opens a multiframe. It confirms that nibble sixteen frames later and then numbers the frames within the multiframe. Errored alignment words are counted so that a short burst does not drop lock. A one-cycle pulse marks each loss of frame or multiframe alignment.

Bits arrive in transmission order. Bit 1 of each time slot comes first. The counter calls bit 1 of a slot index 0, so bit 8 is index 7.

Top module: `e1_frame_align`

## Requirements
- R1: After reset, `in_frame`, `in_mframe`, `lof_pulse` and `lomf_pulse` are all low.
- R2: A single match of the alignment word 0011011 does not set `in_frame`. `in_frame` rises on the bit that completes a second match 512 bit periods after the first, provided bit index 1 of time slot 0 in the frame between them is 1. After that bit, the reported position is slot 1, bit index 0.
- R3: If bit index 1 of time slot 0 in the frame after a candidate match is 0, the candidate is dropped. Alignment then needs a fresh match, marker and match sequence.
- R4: If the second alignment word of a candidate (time slot 0, bit indices 1 to 7) does not equal 0011011, the candidate is dropped and the search starts again.
- R5: While aligned, `slot_idx` and `bit_idx` give the frame position of the next bit: slot = position / 8, bit index = position mod 8, with position 0 being the first bit of time slot 0.
- R6: In a cycle with `bit_en` low, the position outputs, the frame number and the alignment flags do not change.
- R7: While aligned, `in_frame` drops after 3 consecutive errored alignment words, which are checked in the even frames. A correct word clears the error count. On the bit that completes the third errored word, `lof_pulse` is high for exactly one cycle.
- R8: In an aligned even frame, four zero bits in time slot 16 (bit indices 0 to 3) make a multiframe candidate. `frame_num` becomes 0 at that bit. `in_mframe` rises when four zero bits appear again in the same place 16 frames later.
- R9: `frame_num` advances by one at each frame boundary and wraps from 15 to 0.
- R10: While in multiframe alignment, `in_mframe` drops after 2 consecutive errored multiframe nibbles. One error followed by a correct nibble keeps alignment. On the bit that completes the second errored nibble, `lomf_pulse` is high for one cycle.
- R11: `in_mframe` is never high while `in_frame` is low. Losing frame alignment clears multiframe alignment, and after frame re-alignment a new pair of nibbles is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_en | input | 1 | High in cycles that carry one line bit |
| bit_in | input | 1 | Serial line bit, valid when `bit_en` is high |
| in_frame | output | 1 | Frame alignment held |
| in_mframe | output | 1 | Multiframe alignment held |
| slot_idx | output | 5 | Time slot of the next bit |
| bit_idx | output | 3 | Bit index within the slot of the next bit (0 = bit 1) |
| frame_num | output | 4 | Frame number within the multiframe |
| lof_pulse | output | 1 | One-cycle pulse when frame alignment is lost |
| lomf_pulse | output | 1 | One-cycle pulse when multiframe alignment is lost |

## Verification
The bench probes the exact bit on which each flag changes. A detector that locked on the first match, or one bit late, would fail the checks placed one bit before and on the completing bit. Separate runs corrupt only the odd-frame marker, or only the second alignment word. A design that skipped either confirmation would lock two frames early. Error bursts of exactly two separated by a good word, and then three in a row, show whether the loss counter clears and whether its limit is off by one. The multiframe loss limit is tested the same way. A re-lock after frame loss checks that a stale multiframe state is not carried across, and idle cycles check that nothing advances without the enable.

// File: rtl/e1fa_pkg.sv
// Package: shared geometry of the 2.048 Mbit/s frame and the state types
// of the two alignment machines. All positions derive from slot size/count.
package e1fa_pkg;
    localparam int SLOT_BITS  = 8;
    localparam int SLOTS      = 32;
    localparam int FRAME_BITS = SLOT_BITS * SLOTS;
    localparam int POS_W      = $clog2(FRAME_BITS);
    localparam int SLOT_W     = $clog2(SLOTS);
    localparam int BIT_W      = $clog2(SLOT_BITS);
    localparam int MF_FRAMES  = 16;
    localparam int FNUM_W     = $clog2(MF_FRAMES);
    localparam int FAS_LEN    = 7;
    localparam int MFAS_LEN   = 4;
    localparam int SIG_SLOT   = 16;

    typedef logic [POS_W-1:0]  pos_t;
    typedef logic [FNUM_W-1:0] fnum_t;

    localparam logic [FAS_LEN-1:0] FAS_WORD = 7'b0011011;
    // Last bit of the frame, the odd-frame marker, the FAS end and MFAS end.
    localparam pos_t POS_LAST     = pos_t'(FRAME_BITS - 1);
    localparam pos_t POS_MARK     = pos_t'(1);
    localparam pos_t POS_FAS_END  = pos_t'(FAS_LEN);
    localparam pos_t POS_MFAS_END = pos_t'(SIG_SLOT * SLOT_BITS + MFAS_LEN - 1);

    typedef enum logic [1:0] {FS_HUNT, FS_CHK_ODD, FS_CHK_EVEN, FS_LOCK} fsync_t;
    typedef enum logic [1:0] {MS_HUNT, MS_CHK, MS_LOCK} msync_t;
endpackage

// File: rtl/e1fa_pos_counter.sv
// Bit position / frame parity / multiframe frame number counter.
// Assumes: load_fas and load_mf are only raised in cycles with bit_en high.
// A load_fas means the current bit closed an alignment word in an even frame.
module e1fa_pos_counter
    import e1fa_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  bit_en,
    input  logic  load_fas,
    input  logic  load_mf,
    output pos_t  pos_o,
    output logic  even_o,
    output fnum_t fnum_o
);
    pos_t  pos_q;
    logic  even_q;
    fnum_t fnum_q;

    // Advance the bit position, or snap it to the bit after the alignment word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q  <= '0;
            even_q <= 1'b0;
        end else if (bit_en) begin
            if (load_fas) begin
                pos_q  <= POS_FAS_END + pos_t'(1);
                even_q <= 1'b1;
            end else if (pos_q == POS_LAST) begin
                pos_q  <= '0;
                even_q <= ~even_q;
            end else begin
                pos_q  <= pos_q + pos_t'(1);
            end
        end
    end

    // Frame number within the multiframe: cleared on a candidate, bumped per frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fnum_q <= '0;
        end else if (bit_en) begin
            if (load_mf)
                fnum_q <= '0;
            else if (pos_q == POS_LAST && !load_fas)
                fnum_q <= fnum_q + fnum_t'(1);
        end
    end

    assign pos_o  = pos_q;
    assign even_o = even_q;
    assign fnum_o = fnum_q;
endmodule

// File: rtl/e1fa_frame_sync.sv
// Frame alignment machine: hunt for the alignment word, confirm with the
// odd-frame marker and a second word two frames later, then hold lock until
// LOF_LIMIT consecutive errored words. Assumes win_i includes the current bit
// as its LSB and pos_i/even_i describe that current bit.
module e1fa_frame_sync
    import e1fa_pkg::*;
#(
    parameter int LOF_LIMIT = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_en,
    input  logic [FAS_LEN-1:0] win_i,
    input  pos_t               pos_i,
    input  logic               even_i,
    output logic               load_fas_o,
    output logic               locked_o,
    output logic               lof_pulse_o
);
    localparam int ERR_W = $clog2(LOF_LIMIT + 1);

    fsync_t             state_q, state_d;
    logic [ERR_W-1:0]   err_q, err_d;
    logic               lof_d, lof_q;
    logic               fas_ok, at_fas, at_mark;

    assign fas_ok  = (win_i == FAS_WORD);
    assign at_fas  = bit_en && (pos_i == POS_FAS_END) && even_i;
    assign at_mark = bit_en && (pos_i == POS_MARK) && !even_i;
    assign load_fas_o = (state_q == FS_HUNT) && bit_en && fas_ok;

    // Next-state, error count and loss pulse for the alignment machine.
    always_comb begin
        state_d = state_q;
        err_d   = err_q;
        lof_d   = 1'b0;
        unique case (state_q)
            FS_HUNT: begin
                err_d = '0;
                if (load_fas_o) state_d = FS_CHK_ODD;
            end
            FS_CHK_ODD: begin
                if (at_mark) state_d = win_i[0] ? FS_CHK_EVEN : FS_HUNT;
            end
            FS_CHK_EVEN: begin
                if (at_fas) state_d = fas_ok ? FS_LOCK : FS_HUNT;
            end
            FS_LOCK: begin
                if (at_fas) begin
                    if (fas_ok) begin
                        err_d = '0;
                    end else if (err_q == ERR_W'(LOF_LIMIT - 1)) begin
                        err_d   = '0;
                        lof_d   = 1'b1;
                        state_d = FS_HUNT;
                    end else begin
                        err_d = err_q + ERR_W'(1);
                    end
                end
            end
            default: state_d = FS_HUNT;
        endcase
    end

    // State registers of the alignment machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FS_HUNT;
            err_q   <= '0;
            lof_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= err_d;
            lof_q   <= lof_d;
        end
    end

    assign locked_o    = (state_q == FS_LOCK);
    assign lof_pulse_o = lof_q;
endmodule

// File: rtl/e1fa_mf_sync.sv
// Multiframe alignment machine: while frame-aligned, takes an all-zero
// signalling-slot nibble in an even frame as a candidate, confirms it one
// multiframe later and drops after LOMF_LIMIT consecutive errors.
// Assumes nib_zero_i reflects the four most recent bits including the current one.
module e1fa_mf_sync
    import e1fa_pkg::*;
#(
    parameter int LOMF_LIMIT = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  bit_en,
    input  logic  frame_locked_i,
    input  logic  nib_zero_i,
    input  pos_t  pos_i,
    input  logic  even_i,
    input  fnum_t fnum_i,
    output logic  load_mf_o,
    output logic  locked_o,
    output logic  lomf_pulse_o
);
    localparam int ERR_W = $clog2(LOMF_LIMIT + 1);

    msync_t           state_q, state_d;
    logic [ERR_W-1:0] err_q, err_d;
    logic             lomf_d, lomf_q;
    logic             at_nib, at_mf0;

    assign at_nib    = bit_en && (pos_i == POS_MFAS_END) && even_i;
    assign at_mf0    = at_nib && (fnum_i == '0);
    assign load_mf_o = frame_locked_i && (state_q == MS_HUNT) && at_nib && nib_zero_i;

    // Next-state, error count and loss pulse for the multiframe machine.
    always_comb begin
        state_d = state_q;
        err_d   = err_q;
        lomf_d  = 1'b0;
        if (!frame_locked_i) begin
            state_d = MS_HUNT;
            err_d   = '0;
        end else begin
            unique case (state_q)
                MS_HUNT: begin
                    err_d = '0;
                    if (load_mf_o) state_d = MS_CHK;
                end
                MS_CHK: begin
                    if (at_mf0) state_d = nib_zero_i ? MS_LOCK : MS_HUNT;
                end
                MS_LOCK: begin
                    if (at_mf0) begin
                        if (nib_zero_i) begin
                            err_d = '0;
                        end else if (err_q == ERR_W'(LOMF_LIMIT - 1)) begin
                            err_d   = '0;
                            lomf_d  = 1'b1;
                            state_d = MS_HUNT;
                        end else begin
                            err_d = err_q + ERR_W'(1);
                        end
                    end
                end
                default: state_d = MS_HUNT;
            endcase
        end
    end

    // State registers of the multiframe machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MS_HUNT;
            err_q   <= '0;
            lomf_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= err_d;
            lomf_q  <= lomf_d;
        end
    end

    assign locked_o     = (state_q == MS_LOCK);
    assign lomf_pulse_o = lomf_q;
endmodule

// File: rtl/e1_frame_align.sv
// Top: E1 frame and multiframe alignment detector. Keeps a sliding window of
// the last line bits, shares one position counter between the two alignment
// machines and reports the position of the next bit to arrive.
// Assumes one line bit per cycle with bit_en high, bit 1 of each slot first.
module e1_frame_align
    import e1fa_pkg::*;
#(
    parameter int LOF_LIMIT  = 3,
    parameter int LOMF_LIMIT = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bit_en,
    input  logic                        bit_in,
    output logic                        in_frame,
    output logic                        in_mframe,
    output logic [e1fa_pkg::SLOT_W-1:0] slot_idx,
    output logic [e1fa_pkg::BIT_W-1:0]  bit_idx,
    output logic [e1fa_pkg::FNUM_W-1:0] frame_num,
    output logic                        lof_pulse,
    output logic                        lomf_pulse
);
    logic [FAS_LEN-2:0] win_q;
    logic [FAS_LEN-1:0] win_now;
    pos_t               pos;
    logic               even;
    fnum_t              fnum;
    logic               load_fas, load_mf, f_locked, m_locked;

    assign win_now = {win_q, bit_in};

    // Sliding window of the most recent line bits.
    always_ff @(posedge clk) begin
        if (!rst_n)      win_q <= '1;
        else if (bit_en) win_q <= win_now[FAS_LEN-2:0];
    end

    e1fa_pos_counter u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .load_fas (load_fas),
        .load_mf  (load_mf),
        .pos_o    (pos),
        .even_o   (even),
        .fnum_o   (fnum)
    );

    e1fa_frame_sync #(.LOF_LIMIT(LOF_LIMIT)) u_fsync (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_en      (bit_en),
        .win_i       (win_now),
        .pos_i       (pos),
        .even_i      (even),
        .load_fas_o  (load_fas),
        .locked_o    (f_locked),
        .lof_pulse_o (lof_pulse)
    );

    e1fa_mf_sync #(.LOMF_LIMIT(LOMF_LIMIT)) u_msync (
        .clk            (clk),
        .rst_n          (rst_n),
        .bit_en         (bit_en),
        .frame_locked_i (f_locked),
        .nib_zero_i     (win_now[MFAS_LEN-1:0] == '0),
        .pos_i          (pos),
        .even_i         (even),
        .fnum_i         (fnum),
        .load_mf_o      (load_mf),
        .locked_o       (m_locked),
        .lomf_pulse_o   (lomf_pulse)
    );

    assign in_frame  = f_locked;
    assign in_mframe = m_locked && f_locked;
    assign slot_idx  = pos[POS_W-1:BIT_W];
    assign bit_idx   = pos[BIT_W-1:0];
    assign frame_num = fnum;
endmodule

// File: rtl/e1fa_checker.sv
// Checker: temporal properties of the alignment detector, bound to the top.
module e1fa_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_en,
    input logic       in_frame,
    input logic       in_mframe,
    input logic [4:0] slot_idx,
    input logic [2:0] bit_idx,
    input logic [3:0] frame_num,
    input logic       lof_pulse,
    input logic       lomf_pulse
);
    // R11: multiframe alignment only under frame alignment
    a_r11_mf_needs_frame: assert property (@(posedge clk) disable iff (!rst_n)
        in_mframe |-> in_frame);

    // R2: lock is declared on the bit closing an alignment word
    a_r2_lock_position: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_frame) |-> (slot_idx == 5'd1 && bit_idx == 3'd0));

    // R8: multiframe lock lands at frame 0, just after the signalling nibble
    a_r8_mf_lock_position: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_mframe) |-> (frame_num == 4'd0 && slot_idx == 5'd16 && bit_idx == 3'd4));

    // R6: nothing moves without the bit enable
    a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable({slot_idx, bit_idx, frame_num, in_frame, in_mframe}));

    // R5: while aligned, each enabled bit steps the bit index by one
    a_r5_bit_step: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && in_frame) |=> (!in_frame || bit_idx == 3'($past(bit_idx) + 3'd1)));

    // R7: loss pulse coincides with dropped frame alignment and lasts one cycle
    a_r7_lof_drop: assert property (@(posedge clk) disable iff (!rst_n)
        lof_pulse |-> (!in_frame && $past(in_frame)));
    a_r7_lof_single: assert property (@(posedge clk) disable iff (!rst_n)
        lof_pulse |=> !lof_pulse);

    // R10: multiframe loss pulse coincides with dropped multiframe alignment
    a_r10_lomf_drop: assert property (@(posedge clk) disable iff (!rst_n)
        lomf_pulse |-> (!in_mframe && $past(in_mframe)));
endmodule

bind e1_frame_align e1fa_checker chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .in_frame   (in_frame),
    .in_mframe  (in_mframe),
    .slot_idx   (slot_idx),
    .bit_idx    (bit_idx),
    .frame_num  (frame_num),
    .lof_pulse  (lof_pulse),
    .lomf_pulse (lomf_pulse)
);

// File: tb/e1_frame_align_tb.sv
// Scoreboard bench: the driver streams generated frames and queues expected
// outputs; a monitor pops and compares them one step after each falling edge.
module e1_frame_align_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       bit_in = 1'b1;
    logic       in_frame, in_mframe, lof_pulse, lomf_pulse;
    logic [4:0] slot_idx;
    logic [2:0] bit_idx;
    logic [3:0] frame_num;

    always #(CLK_PERIOD/2) clk = ~clk;

    e1_frame_align dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .bit_in     (bit_in),
        .in_frame   (in_frame),
        .in_mframe  (in_mframe),
        .slot_idx   (slot_idx),
        .bit_idx    (bit_idx),
        .frame_num  (frame_num),
        .lof_pulse  (lof_pulse),
        .lomf_pulse (lomf_pulse)
    );

    typedef struct {
        string tag;
        logic  inf, mf, lof, lomf;
        int    slot, bitn, fnum;
        bit    use_pos, use_fnum;
    } exp_t;

    exp_t         sb_q[$];
    int           checks = 0;
    int           failures = 0;
    bit           done = 1'b0;
    int           cur_f, cur_p;
    logic [159:0] bad_fas, bad_odd, bad_mfas;

    // Stream generator: bit at position p of frame f under the error masks.
    function automatic logic gen(int f, int p);
        logic [6:0] w;
        if (p == 0) return 1'b1;
        if (p <= 7) begin
            if (f % 2 == 0) begin
                w = bad_fas[f] ? 7'b0011111 : 7'b0011011;
                return w[7-p];
            end
            if (p == 1) return !bad_odd[f];
            return 1'b1;
        end
        if (p >= 128 && p <= 131) begin
            if (f % 16 == 0) return bad_mfas[f];
            return 1'b1;
        end
        return 1'b1;
    endfunction

    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_in = b;
        bit_en = 1'b1;
    endtask

    task automatic send_ones(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b1);
    endtask

    // Send the stream up to and including bit p of frame f.
    task automatic send_to(input int f, input int p);
        while (cur_f < f || (cur_f == f && cur_p <= p)) begin
            send_bit(gen(cur_f, cur_p));
            if (cur_p == 255) begin
                cur_p = 0;
                cur_f++;
            end else begin
                cur_p++;
            end
        end
    endtask

    // Queue the expected outputs after the last bit sent (next bit = cur_p).
    task automatic expect_out(input string tag, input logic inf, input logic mf,
                              input logic lof, input logic lomf,
                              input bit use_pos, input bit use_fnum);
        exp_t e;
        @(negedge clk);
        bit_en = 1'b0;
        e.tag = tag; e.inf = inf; e.mf = mf; e.lof = lof; e.lomf = lomf;
        e.slot = cur_p / 8; e.bitn = cur_p % 8; e.fnum = cur_f % 16;
        e.use_pos = use_pos; e.use_fnum = use_fnum;
        sb_q.push_back(e);
    endtask

    task automatic cmp(input string tag, input string what, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp_v);
        end
    endtask

    // Monitor: compare queued expectations against the outputs.
    always @(negedge clk) begin
        exp_t e;
        #1;
        while (sb_q.size() > 0) begin
            e = sb_q.pop_front();
            cmp(e.tag, "in_frame", int'(in_frame), int'(e.inf));
            cmp(e.tag, "in_mframe", int'(in_mframe), int'(e.mf));
            cmp(e.tag, "lof_pulse", int'(lof_pulse), int'(e.lof));
            cmp(e.tag, "lomf_pulse", int'(lomf_pulse), int'(e.lomf));
            if (e.use_pos) begin
                cmp(e.tag, "slot_idx", int'(slot_idx), e.slot);
                cmp(e.tag, "bit_idx", int'(bit_idx), e.bitn);
            end
            if (e.use_fnum) cmp(e.tag, "frame_num", int'(frame_num), e.fnum);
        end
    end

    task automatic do_reset();
        bit_en = 1'b0;
        rst_n  = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_f = 0; cur_p = 0;
        bad_fas = '0; bad_odd = '0; bad_mfas = '0;
    endtask

    initial begin
        do_reset();
        expect_out("R1 reset", 0, 0, 0, 0, 0, 0);

        // Phase A: odd-frame marker of frame 1 corrupted.
        do_reset();
        bad_odd[1] = 1'b1;
        send_ones(37);
        send_to(0, 7);   expect_out("R2 single match", 0, 0, 0, 0, 0, 0);
        send_to(2, 7);   expect_out("R3 marker fail", 0, 0, 0, 0, 0, 0);
        send_to(4, 6);   expect_out("R3 before relock", 0, 0, 0, 0, 0, 0);
        send_to(4, 7);   expect_out("R3 relock", 1, 0, 0, 0, 1, 0);

        // Phase B: second alignment word of the candidate corrupted.
        do_reset();
        bad_fas[2] = 1'b1;
        send_ones(11);
        send_to(2, 7);   expect_out("R4 bad second word", 0, 0, 0, 0, 0, 0);
        send_to(4, 7);   expect_out("R4 new candidate", 0, 0, 0, 0, 0, 0);
        send_to(6, 7);   expect_out("R4 relock", 1, 0, 0, 0, 1, 0);

        // Phase C: clean lock, multiframe, error bursts and re-lock.
        do_reset();
        bad_fas[34] = 1'b1; bad_fas[36] = 1'b1;
        bad_fas[40] = 1'b1; bad_fas[42] = 1'b1; bad_fas[44] = 1'b1;
        bad_mfas[80] = 1'b1; bad_mfas[112] = 1'b1; bad_mfas[128] = 1'b1;
        send_ones(100);
        send_to(2, 6);   expect_out("R2 one bit early", 0, 0, 0, 0, 0, 0);
        send_to(2, 7);   expect_out("R2 lock", 1, 0, 0, 0, 1, 0);
        repeat (5) @(negedge clk);
        expect_out("R6 idle hold", 1, 0, 0, 0, 1, 0);
        send_to(3, 100); expect_out("R5 position", 1, 0, 0, 0, 1, 0);
        send_to(16, 131); expect_out("R8 candidate", 1, 0, 0, 0, 1, 1);
        send_to(32, 130); expect_out("R8 before confirm", 1, 0, 0, 0, 1, 0);
        send_to(32, 131); expect_out("R8 confirm", 1, 1, 0, 0, 1, 1);
        send_to(37, 20);  expect_out("R9 frame count", 1, 1, 0, 0, 1, 1);
        send_to(38, 7);   expect_out("R7 two errors then good", 1, 1, 0, 0, 1, 0);
        send_to(42, 7);   expect_out("R7 two in a row", 1, 1, 0, 0, 1, 0);
        send_to(44, 7);   expect_out("R7 third error", 0, 0, 1, 0, 0, 0);
        expect_out("R7 pulse one cycle", 0, 0, 0, 0, 0, 0);
        send_to(48, 7);   expect_out("R11 relock without mf", 1, 0, 0, 0, 1, 0);
        send_to(63, 200); expect_out("R11 fresh pair needed", 1, 0, 0, 0, 1, 0);
        send_to(64, 131); expect_out("R8 mf relock", 1, 1, 0, 0, 1, 1);
        send_to(79, 255); expect_out("R9 wrap to zero", 1, 1, 0, 0, 1, 1);
        send_to(112, 131); expect_out("R10 isolated errors", 1, 1, 0, 0, 1, 1);
        send_to(128, 131); expect_out("R10 second error", 1, 0, 0, 1, 1, 0);

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule